// File: doc/BRIEF.md
# Sticky Fault Status Register

This block gathers fault conditions raised by analog monitors elsewhere in a rate-sensor die and holds each one in a flag until the host has seen it. The monitors cover resonator lock, excess quadrature, non-volatile memory checksum, power-on initialisation, supply overvoltage and undervoltage, resonator amplitude, and a mild or severe continuous self-test deviation. Every monitor except quadrature arrives asynchronously. Each flag is cleared by the command decoder when the full register is read, or when a sensor-data command is served. The combined flags and a reduced view are presented for the register read path and for appending to every sensor-data reply.

The block derives a power flag from the two supply flags and a fail flag from the conditions that make rate data untrustworthy. It also produces the two-bit status code for sensor-data replies. A host-driven check request forces every monitored condition on, after a programmable number of cycles, so that the detection and reporting path can be exercised. Once the request drops, the forced conditions persist for the same number of cycles before they decay.

Top module: `fault_sticky_reg`

## Requirements
- R1: A condition on any monitor input reaches its flag at the third rising clock edge after it first appears, two of those edges being synchroniser stages. The flag then stays set until a clear strobe arrives. Flag register positions: 0 lock, 1 quadrature, 2 memory, 3 init, 4 undervoltage, 5 overvoltage, 6 amplitude, 7 power, 8 self-test (set by the mild or the severe self-test input), 9 check, 10 fail.
- R2: A read strobe or a serve strobe clears all flags at the next edge. A flag whose synchronised condition is present at that same edge stays set, because set wins over clear.
- R3: The quadrature flag sets only when the unsigned quadrature level is strictly greater than QUAD_LIMIT (default 4096). A level equal to the limit does not set it.
- R4: The power flag (bit 7) is set exactly when the overvoltage or the undervoltage flag is set.
- R5: The fail flag (bit 10) latches when a lock fault or a severe self-test fault is present. A mild self-test fault alone does not set it.
- R6: The reply view has 8 bits: 0 lock, 1 quadrature, 2 memory, 3 init, 4 power, 5 self-test OR amplitude, 6 check, 7 fail. Overvoltage and undervoltage do not appear in it individually.
- R7: The status code is 2'b10 while the check request is high. Otherwise it is 2'b00 while a synchronised lock or severe self-test condition (real or forced) is present, and 2'b01 in all other cases. It is never 2'b11.
- R8: Check bit 9 follows the check request. All conditions become forced after the request has been high for CHK_HOLD consecutive edges. Forcing ends after the request has been low for CHK_HOLD consecutive edges.
- R9: After reset all flags read zero and the status code is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_lock_a | input | 1 | Resonator lock lost (asynchronous) |
| mon_nvm_a | input | 1 | Memory checksum failure (asynchronous) |
| mon_init_a | input | 1 | Power-on initialisation failure (asynchronous) |
| mon_ov_a | input | 1 | Regulator overvoltage (asynchronous) |
| mon_uv_a | input | 1 | Regulator undervoltage (asynchronous) |
| mon_amp_a | input | 1 | Resonator amplitude too low (asynchronous) |
| mon_st_mild_a | input | 1 | Self-test outside the narrow window (asynchronous) |
| mon_st_severe_a | input | 1 | Self-test outside the wide window (asynchronous) |
| quad_level | input | QW | Instantaneous quadrature magnitude, synchronous to clk |
| chk_req | input | 1 | Check (fault injection) request from the host |
| clr_read | input | 1 | Strobe: full flag register was read |
| clr_serve | input | 1 | Strobe: a sensor-data command was served |
| flag_reg | output | 11 | Full sticky flag register |
| reply_flags | output | 8 | Reduced view for sensor-data replies |
| data_status | output | 2 | Status code for sensor-data replies |

## Verification
A flag that fails to hold would read zero on flag_reg one cycle after its input drops, while the reference still expects it set. A flag that misses the set-over-clear rule would read zero on the cycle after a strobe, although its condition is still present. A wrong synchroniser depth moves every flag edge, and the status code edge, by a cycle, so any shift in latency shows at once. A broken force timer shows as forced flags, or a 2'b00 status, appearing or decaying one cycle off the CHK_HOLD count. Because the reference is compared with every output on every cycle, each of these faults is reported in the cycle it first becomes visible.

// File: rtl/fsr_pkg.sv
// Shared indices and codes for the sticky fault status register.
// Assumes: all vectors are little-endian, index 0 is the LSB.
package fsr_pkg;
    // Condition vector (after synchronisation)
    localparam int NCOND  = 9;
    localparam int C_LOCK = 0;
    localparam int C_QUAD = 1;
    localparam int C_NVM  = 2;
    localparam int C_INIT = 3;
    localparam int C_OV   = 4;
    localparam int C_UV   = 5;
    localparam int C_AMP  = 6;
    localparam int C_STM  = 7;
    localparam int C_STX  = 8;

    // Sticky latch vector
    localparam int NLATCH = 9;
    localparam int L_LOCK = 0;
    localparam int L_QUAD = 1;
    localparam int L_NVM  = 2;
    localparam int L_INIT = 3;
    localparam int L_OV   = 4;
    localparam int L_UV   = 5;
    localparam int L_AMP  = 6;
    localparam int L_ST   = 7;
    localparam int L_FAIL = 8;

    // Full flag register layout
    localparam int REG_W  = 11;
    localparam int F_LOCK = 0;
    localparam int F_QUAD = 1;
    localparam int F_NVM  = 2;
    localparam int F_INIT = 3;
    localparam int F_UV   = 4;
    localparam int F_OV   = 5;
    localparam int F_AMP  = 6;
    localparam int F_PWR  = 7;
    localparam int F_ST   = 8;
    localparam int F_CHK  = 9;
    localparam int F_FAIL = 10;

    // Reply view layout
    localparam int RSP_W  = 8;
    localparam int R_LOCK = 0;
    localparam int R_QUAD = 1;
    localparam int R_NVM  = 2;
    localparam int R_INIT = 3;
    localparam int R_PWR  = 4;
    localparam int R_ST   = 5;
    localparam int R_CHK  = 6;
    localparam int R_FAIL = 7;

    typedef enum logic [1:0] {
        ST_ERROR = 2'b00,
        ST_VALID = 2'b01,
        ST_CHECK = 2'b10,
        ST_RW    = 2'b11
    } status_e;
endpackage

// File: rtl/fsr_sync.sv
// Multi-stage synchroniser for a vector of independent level signals.
// Assumes: each bit is an independent level; no bus coherency is needed.
module fsr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= d_i;
                end
            end else begin : g_next
                // Later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/fsr_chk_timer.sv
// Check-mode force timer: force_o follows chk_i only after chk_i has
// differed from it for HOLD consecutive clock edges.
// Assumes: chk_i is synchronous to clk; HOLD >= 1.
module fsr_chk_timer #(
    parameter int HOLD = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_i,
    output logic force_o
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] cnt_q;
    logic          force_q;

    // Count edges of disagreement; flip the force level when the count completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            force_q <= 1'b0;
        end else if (chk_i == force_q) begin
            cnt_q   <= '0;
        end else if (cnt_q == CW'(HOLD - 1)) begin
            cnt_q   <= '0;
            force_q <= chk_i;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign force_o = force_q;

    assert_force_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_q) |-> $past(chk_i));
    assert_force_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_q) |-> !$past(chk_i));
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(HOLD - 1));
endmodule

// File: rtl/fsr_latch.sv
// Bank of sticky flags: set wins over clear, clear is a single strobe.
// Assumes: set_i is already synchronous to clk.
module fsr_latch #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Hold flags, drop them on clear, re-set any still-present condition
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (clr_i ? '0 : q) | set_i;
    end

    assign q_o = q;

    assert_hold_without_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((q & $past(q)) == $past(q)));
    assert_set_beats_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/fault_sticky_reg.sv
// Sticky fault status register. Synchronises asynchronous monitor levels,
// latches them until a read or serve strobe, derives power and fail flags,
// and produces the full register, the reply view and the status code.
// Assumes: quad_level, chk_req and clear strobes are synchronous to clk.
module fault_sticky_reg
    import fsr_pkg::*;
#(
    parameter int QW         = 16,
    parameter int QUAD_LIMIT = 4096,
    parameter int SYNC_DEPTH = 2,
    parameter int CHK_HOLD   = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_lock_a,
    input  logic              mon_nvm_a,
    input  logic              mon_init_a,
    input  logic              mon_ov_a,
    input  logic              mon_uv_a,
    input  logic              mon_amp_a,
    input  logic              mon_st_mild_a,
    input  logic              mon_st_severe_a,
    input  logic [QW-1:0]     quad_level,
    input  logic              chk_req,
    input  logic              clr_read,
    input  logic              clr_serve,
    output logic [REG_W-1:0]  flag_reg,
    output logic [RSP_W-1:0]  reply_flags,
    output logic [1:0]        data_status
);
    logic [NCOND-1:0]  cond_raw;
    logic [NCOND-1:0]  cond_s;
    logic [NCOND-1:0]  cond_eff;
    logic [NLATCH-1:0] set_vec;
    logic [NLATCH-1:0] lat;
    logic              force_on;
    logic              clr_any;
    status_e           status;

    // Gather raw monitor levels into the condition vector
    always_comb begin
        cond_raw         = '0;
        cond_raw[C_LOCK] = mon_lock_a;
        cond_raw[C_QUAD] = (quad_level > QW'(QUAD_LIMIT));
        cond_raw[C_NVM]  = mon_nvm_a;
        cond_raw[C_INIT] = mon_init_a;
        cond_raw[C_OV]   = mon_ov_a;
        cond_raw[C_UV]   = mon_uv_a;
        cond_raw[C_AMP]  = mon_amp_a;
        cond_raw[C_STM]  = mon_st_mild_a;
        cond_raw[C_STX]  = mon_st_severe_a;
    end

    fsr_sync #(.W(NCOND), .STAGES(SYNC_DEPTH)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cond_raw),
        .q_o   (cond_s)
    );

    fsr_chk_timer #(.HOLD(CHK_HOLD)) i_chk_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_i   (chk_req),
        .force_o (force_on)
    );

    // Forced conditions OR real ones
    assign cond_eff = cond_s | {NCOND{force_on}};
    assign clr_any  = clr_read | clr_serve;

    // Map conditions onto latch set inputs, including the fail source
    always_comb begin
        set_vec         = '0;
        set_vec[L_LOCK] = cond_eff[C_LOCK];
        set_vec[L_QUAD] = cond_eff[C_QUAD];
        set_vec[L_NVM]  = cond_eff[C_NVM];
        set_vec[L_INIT] = cond_eff[C_INIT];
        set_vec[L_OV]   = cond_eff[C_OV];
        set_vec[L_UV]   = cond_eff[C_UV];
        set_vec[L_AMP]  = cond_eff[C_AMP];
        set_vec[L_ST]   = cond_eff[C_STM] | cond_eff[C_STX];
        set_vec[L_FAIL] = cond_eff[C_LOCK] | cond_eff[C_STX];
    end

    fsr_latch #(.W(NLATCH)) i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_any),
        .q_o   (lat)
    );

    // Assemble the full register with derived power flag
    always_comb begin
        flag_reg         = '0;
        flag_reg[F_LOCK] = lat[L_LOCK];
        flag_reg[F_QUAD] = lat[L_QUAD];
        flag_reg[F_NVM]  = lat[L_NVM];
        flag_reg[F_INIT] = lat[L_INIT];
        flag_reg[F_UV]   = lat[L_UV];
        flag_reg[F_OV]   = lat[L_OV];
        flag_reg[F_AMP]  = lat[L_AMP];
        flag_reg[F_PWR]  = lat[L_OV] | lat[L_UV];
        flag_reg[F_ST]   = lat[L_ST];
        flag_reg[F_CHK]  = chk_req;
        flag_reg[F_FAIL] = lat[L_FAIL];
    end

    // Reply view folds amplitude into self-test and hides the supply detail
    always_comb begin
        reply_flags         = '0;
        reply_flags[R_LOCK] = lat[L_LOCK];
        reply_flags[R_QUAD] = lat[L_QUAD];
        reply_flags[R_NVM]  = lat[L_NVM];
        reply_flags[R_INIT] = lat[L_INIT];
        reply_flags[R_PWR]  = lat[L_OV] | lat[L_UV];
        reply_flags[R_ST]   = lat[L_ST] | lat[L_AMP];
        reply_flags[R_CHK]  = chk_req;
        reply_flags[R_FAIL] = lat[L_FAIL];
    end

    // Status code: check mode first, then live fail conditions
    always_comb begin
        if (chk_req)                               status = ST_CHECK;
        else if (cond_eff[C_LOCK] | cond_eff[C_STX]) status = ST_ERROR;
        else                                       status = ST_VALID;
    end

    assign data_status = status;

    assert_never_rw_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_status != ST_RW);
    assert_fail_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat[L_FAIL]) |-> $past(cond_eff[C_LOCK] | cond_eff[C_STX]));
    assert_mild_only_no_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_req && !cond_s[C_LOCK] && !cond_s[C_STX] && !force_on) |-> data_status == ST_VALID);
endmodule

// File: tb/test_fault_sticky_reg.sv
`timescale 1ns/1ps
module test_fault_sticky_reg;
    localparam int QW    = 16;
    localparam int QLIM  = 4096;
    localparam int HOLD  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_a = 0, nvm_a = 0, init_a = 0, ov_a = 0, uv_a = 0, amp_a = 0, stm_a = 0, stx_a = 0;
    logic [QW-1:0] quad = '0;
    logic chk = 0, clr_rd = 0, clr_sv = 0;
    logic [10:0] flag_reg;
    logic [7:0]  reply_flags;
    logic [1:0]  data_status;

    always #2.5 clk = ~clk;

    fault_sticky_reg #(.QW(QW), .QUAD_LIMIT(QLIM), .SYNC_DEPTH(2), .CHK_HOLD(HOLD)) i_fault_sticky_reg (
        .clk(clk), .rst_n(rst_n),
        .mon_lock_a(lock_a), .mon_nvm_a(nvm_a), .mon_init_a(init_a),
        .mon_ov_a(ov_a), .mon_uv_a(uv_a), .mon_amp_a(amp_a),
        .mon_st_mild_a(stm_a), .mon_st_severe_a(stx_a),
        .quad_level(quad), .chk_req(chk), .clr_read(clr_rd), .clr_serve(clr_sv),
        .flag_reg(flag_reg), .reply_flags(reply_flags), .data_status(data_status)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Behavioural reference: conditions delayed by a two-entry queue,
    // sticky flags kept as named bits, force timer as an integer run length.
    bit cq [$];
    bit [8:0] hist [$];
    bit m_lock, m_quad, m_nvm, m_init, m_ov, m_uv, m_amp, m_st, m_fail;
    bit m_force = 0;
    int m_run = 0;
    bit started = 0;
    bit cleared_last = 0;
    bit [8:0] seen;

    function automatic bit [8:0] raw_now();
        return {stx_a, stm_a, amp_a, uv_a, ov_a, init_a, nvm_a, (int'(quad) > QLIM), lock_a};
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            hist = {9'd0, 9'd0};
            {m_lock, m_quad, m_nvm, m_init, m_ov, m_uv, m_amp, m_st, m_fail} = '0;
            m_force = 0; m_run = 0; cleared_last = 0;
        end else begin
            bit [8:0] e;
            e = hist[0] | {9{m_force}};
            if (clr_rd || clr_sv) begin
                {m_lock, m_quad, m_nvm, m_init, m_ov, m_uv, m_amp, m_st, m_fail} = '0;
            end
            cleared_last = clr_rd || clr_sv;
            m_lock |= e[0]; m_quad |= e[1]; m_nvm |= e[2]; m_init |= e[3];
            m_ov   |= e[4]; m_uv   |= e[5]; m_amp |= e[6];
            m_st   |= e[7] | e[8];
            m_fail |= e[0] | e[8];
            if (chk != m_force) begin
                m_run++;
                if (m_run == HOLD) begin m_force = chk; m_run = 0; end
            end else m_run = 0;
            void'(hist.pop_front());
            hist.push_back(raw_now());
        end
    end

    // Compare every output away from the active edge
    always @(negedge clk) begin
        if (started) begin
            bit [10:0] er;
            bit [7:0]  ep;
            bit [8:0]  se;
            int        es;
            string     t1;
            se = hist[0] | {9{m_force}};
            er = {m_fail, chk, m_st, (m_ov | m_uv), m_amp, m_ov, m_uv, m_init, m_nvm, m_quad, m_lock};
            ep = {m_fail, chk, (m_st | m_amp), (m_ov | m_uv), m_init, m_nvm, m_quad, m_lock};
            es = chk ? 2 : ((se[0] | se[8]) ? 0 : 1);
            if (!rst_n) begin
                check("R9 flags in reset", int'(flag_reg), 0);
                check("R9 status in reset", int'(data_status), 1);
            end else begin
                t1 = cleared_last ? "R2 sticky after clear" : "R1 sticky flags";
                check(t1, int'(flag_reg & 11'h17D), int'(er & 11'h17D));
                check("R3 quadrature flag", int'(flag_reg[1]), int'(er[1]));
                check("R4 power flag", int'(flag_reg[7]), int'(er[7]));
                check("R5 fail flag", int'(flag_reg[10]), int'(er[10]));
                check("R8 check bit", int'(flag_reg[9]), int'(er[9]));
                check("R6 reply view", int'(reply_flags), int'(ep));
                check("R7 status code", int'(data_status), es);
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_clear(bit which);
        @(negedge clk); #1;
        if (which) clr_sv = 1; else clr_rd = 1;
        @(negedge clk); #1;
        clr_rd = 0; clr_sv = 0;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(2);
        // R1/R5/R7: single-cycle lock pulse latches and holds
        lock_a = 1; step(1); lock_a = 0; step(6);
        pulse_clear(0); step(3);
        // R2: condition present across a clear re-asserts
        ov_a = 1; step(5); pulse_clear(1); step(2); pulse_clear(0); ov_a = 0; step(4);
        pulse_clear(1); step(2);
        // R4/R6: undervoltage, amplitude fold into reply view
        uv_a = 1; amp_a = 1; step(4); uv_a = 0; amp_a = 0; step(3);
        pulse_clear(0); step(2);
        // R5: mild self-test alone, then severe
        stm_a = 1; step(5); stm_a = 0; step(3); pulse_clear(0);
        stx_a = 1; step(5); stx_a = 0; step(3); pulse_clear(1);
        nvm_a = 1; init_a = 1; step(3); nvm_a = 0; init_a = 0; step(3);
        pulse_clear(0); step(2);
        // R3: quadrature threshold boundary
        quad = 16'd4096; step(6);
        quad = 16'd4097; step(5);
        quad = 16'd0; pulse_clear(0); step(3);
        quad = 16'hFFFF; step(2); quad = 16'd100; step(4); pulse_clear(1); step(3);
        // R8: check mode, short request first then a full hold
        chk = 1; step(HOLD - 2); chk = 0; step(5);
        chk = 1; step(HOLD + 10);
        pulse_clear(0); step(3);
        chk = 0; step(HOLD / 2); pulse_clear(1); step(HOLD); pulse_clear(0); step(5);
        // Mixed stimulus
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #1;
            lock_a = ($urandom_range(0, 15) == 0);
            nvm_a  = ($urandom_range(0, 15) == 0);
            init_a = ($urandom_range(0, 15) == 0);
            ov_a   = ($urandom_range(0, 11) == 0);
            uv_a   = ($urandom_range(0, 11) == 0);
            amp_a  = ($urandom_range(0, 11) == 0);
            stm_a  = ($urandom_range(0, 9) == 0);
            stx_a  = ($urandom_range(0, 19) == 0);
            quad   = QW'($urandom_range(4090, 4102));
            clr_rd = ($urandom_range(0, 5) == 0);
            clr_sv = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 59) == 0) chk = ~chk;
        end
        @(negedge clk); #1;
        {lock_a, nvm_a, init_a, ov_a, uv_a, amp_a, stm_a, stx_a} = '0;
        clr_rd = 0; clr_sv = 0; chk = 0; quad = '0;
        step(2 * HOLD + 5);
        pulse_clear(0); step(4);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule